// File: doc/BRIEF.md
# Dadda Partial-Product Reduction Tree with Lookahead Adder

This block takes the nine rows of partial products that a radix-8 Booth recoder builds for a 24-bit by 24-bit significand multiply. It returns their 48-bit sum, which is the significand product. Each row arrives already shifted into place as a 48-bit vector. Sign handling and negation are expressed inside the rows, so the true product equals the sum of all rows modulo 2^48. The recoder that builds the rows is a separate block, and so are normalisation, rounding, exponent and sign logic.

The reduction places full adders (3:2 counters) and half adders (2:2 counters) by the Dadda rule. The height limits are found by working back from 2: each limit is the largest integer no greater than 1.5 times the next one. For nine rows this gives four stages with limits 6, 4, 3 and 2. In each stage, counters are placed only in columns whose height, including the carries arriving from the column below, exceeds that stage's limit. A counter puts its sum in its own column and its carry in the next higher column. The last two rows go to an adder built from 4-bit lookahead groups, with a group-level carry lookahead between the groups. The carry out of bit 47 is dropped.

The datapath is purely combinational. A parameter adds an output register with asynchronous active-low reset. The block has no control states: the output is either a direct function of the rows, or that function delayed by one clock.

Top module: `dadda_mul_tree`

## Requirements
- R1: The product output equals the sum of all input rows modulo 2^W (W=48 by default), for any row contents.
- R2: With REG_OUT=1 the output shows the sum of the rows present at a rising clock edge from that edge on. With REG_OUT=0 the output follows the rows in the same cycle.
- R3: With REG_OUT=1, a low level on rst_n clears the output to zero at once, without waiting for a clock edge. The output stays zero while rst_n is low.
- R4: The input rows are built by radix-8 recoding of an unsigned 24-bit multiplier b and sit at bit offsets 3*i. Row i holds the two's complement of d_i*a, where d_i = -4*b[3i+2] + 2*b[3i+1] + b[3i] + b[3i-1], with b[-1] and the bits above b[23] taken as zero. For such rows the output equals the full 48-bit product a*b.
- R5: The carry out of the top bit is discarded. Nine rows of all ones give 2^48-9 (48'hFFFF_FFFF_FFF7).
- R6: A carry crosses every 4-bit lookahead group boundary. A row of all ones plus a row holding 1 gives zero, and 48'h0000_0000_0FFF plus 1 gives 48'h0000_0000_1000.
- R7: All-zero rows give a zero output.
- R8: With REG_OUT=1, while the rows stay unchanged the output stays unchanged.
- R9: When only one row is nonzero, the output equals that row unchanged, whichever row position it occupies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| rows_i | input | NROWS*W | Row r occupies bits [r*W +: W], already aligned |
| prod_o | output | W | Sum of the rows modulo 2^W |

## Verification
The bench builds two copies with NROWS=9, W=48 and GW=4: one with REG_OUT=1 and one with REG_OUT=0. This lets a single stimulus check the one-cycle latency against the same-cycle path. With twelve lookahead groups, the all-ones-plus-one and 12-bit-boundary patterns drive carries through the group-to-group lookahead. The full-height nine-row matrix exercises all four Dadda stages in every column. Random rows, single-row patterns at each position, and Booth-recoded significand pairs give the result three distinct kinds of input, with an all-ones case for the discarded top carry.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

    localparam int MAX_COLS = 256;

    typedef enum logic [1:0] {
        PL_HEIGHT,
        PL_CIN,
        PL_FA,
        PL_HA
    } plan_sel_e;

    // Largest Dadda limit strictly below n (sequence 2,3,4,6,9,13,...)
    function automatic int limit_below(input int n);
        int d;
        int nx;
        d  = 2;
        nx = (d * 3) / 2;
        while (nx < n) begin
            d  = nx;
            nx = (d * 3) / 2;
        end
        return d;
    endfunction

    function automatic int num_stages(input int n);
        int h;
        int cnt;
        h   = n;
        cnt = 0;
        while (h > 2) begin
            h   = limit_below(h);
            cnt = cnt + 1;
        end
        return cnt;
    endfunction

    function automatic int stage_limit(input int n, input int s);
        int h;
        h = n;
        for (int i = 0; i <= s; i++) h = limit_below(h);
        return h;
    endfunction

    // Counter placement for column c entering stage s
    function automatic int col_plan(input int n, input int w, input int s,
                                    input int c, input plan_sel_e what);
        int h [MAX_COLS];
        int cin;
        int d;
        int e;
        int f;
        int ha;
        for (int col = 0; col < MAX_COLS; col++) h[col] = n;
        for (int st = 0; st <= s; st++) begin
            d   = stage_limit(n, st);
            cin = 0;
            for (int col = 0; col < w; col++) begin
                e = h[col] + cin - d;
                if (e > 0) begin
                    f  = e / 2;
                    ha = e % 2;
                end else begin
                    f  = 0;
                    ha = 0;
                end
                if (st == s && col == c) begin
                    unique case (what)
                        PL_HEIGHT: return h[col];
                        PL_CIN:    return cin;
                        PL_FA:     return f;
                        PL_HA:     return ha;
                    endcase
                end
                h[col] = h[col] + cin - 2 * f - ha;
                cin    = f + ha;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/dadda_fa.sv
module dadda_fa (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic sum_o,
    output logic cy_o
);
    logic x;
    assign x     = a_i ^ b_i;
    assign sum_o = x ^ c_i;
    assign cy_o  = (a_i & b_i) | (c_i & x);
endmodule

// File: rtl/dadda_ha.sv
module dadda_ha (
    input  logic a_i,
    input  logic b_i,
    output logic sum_o,
    output logic cy_o
);
    assign sum_o = a_i ^ b_i;
    assign cy_o  = a_i & b_i;
endmodule

// File: rtl/dadda_reduce.sv
module dadda_reduce
    import dadda_pkg::*;
#(
    parameter int NROWS = 9,
    parameter int W     = 48
) (
    input  logic [NROWS*W-1:0] rows_i,
    output logic [W-1:0]       row_a_o,
    output logic [W-1:0]       row_b_o
);
    localparam int NSTG = num_stages(NROWS);

    logic [NROWS-1:0] in0 [W];
    logic [NROWS-1:0] mat [1:NSTG][W];
    logic [NROWS-1:0] cyv [NSTG][W];

    always_comb begin
        for (int c = 0; c < W; c++)
            for (int r = 0; r < NROWS; r++)
                in0[c][r] = rows_i[r*W + c];
    end

    for (genvar s = 0; s < NSTG; s++) begin : g_stg
        for (genvar c = 0; c < W; c++) begin : g_col
            localparam int H  = col_plan(NROWS, W, s, c, PL_HEIGHT);
            localparam int CI = col_plan(NROWS, W, s, c, PL_CIN);
            localparam int F  = col_plan(NROWS, W, s, c, PL_FA);
            localparam int HA = col_plan(NROWS, W, s, c, PL_HA);
            localparam int NH = col_plan(NROWS, W, s + 1, c, PL_HEIGHT);
            localparam int P  = H - 3 * F - 2 * HA;

            logic [NROWS-1:0] cur;
            logic [NROWS-1:0] cin_v;
            logic [NROWS-1:0] nxt;
            logic [NROWS-1:0] cyl;

            if (s == 0) begin : g_src0
                assign cur = in0[c];
            end else begin : g_srcn
                assign cur = mat[s][c];
            end

            if (c == 0) begin : g_cin0
                assign cin_v = '0;
            end else begin : g_cinn
                assign cin_v = cyv[s][c-1];
            end

            for (genvar k = 0; k < F; k++) begin : g_fa
                dadda_fa u_fa (
                    .a_i  (cur[3*k]),
                    .b_i  (cur[3*k+1]),
                    .c_i  (cur[3*k+2]),
                    .sum_o(nxt[k]),
                    .cy_o (cyl[k])
                );
            end

            if (HA == 1) begin : g_ha
                dadda_ha u_ha (
                    .a_i  (cur[3*F]),
                    .b_i  (cur[3*F+1]),
                    .sum_o(nxt[F]),
                    .cy_o (cyl[F])
                );
            end

            for (genvar j = 0; j < P; j++) begin : g_pass
                assign nxt[F+HA+j] = cur[3*F+2*HA+j];
            end

            for (genvar j = 0; j < CI; j++) begin : g_carry
                assign nxt[F+HA+P+j] = cin_v[j];
            end

            if (NH < NROWS) begin : g_nz
                assign nxt[NROWS-1:NH] = '0;
            end

            if (F + HA < NROWS) begin : g_cz
                assign cyl[NROWS-1:F+HA] = '0;
            end

            assign mat[s+1][c] = nxt;
            assign cyv[s][c]   = cyl;
        end
    end

    for (genvar c = 0; c < W; c++) begin : g_out
        assign row_a_o[c] = mat[NSTG][c][0];
        assign row_b_o[c] = mat[NSTG][c][1];
    end

endmodule

// File: rtl/dadda_cla.sv
module dadda_cla #(
    parameter int W  = 48,
    parameter int GW = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    localparam int NG = W / GW;

    logic [W-1:0]  p;
    logic [W-1:0]  g;
    logic [W-1:0]  cy;
    logic [NG-1:0] grp_g;
    logic [NG-1:0] grp_p;
    logic [NG-1:0] grp_c;

    always_comb begin
        p = a_i ^ b_i;
        g = a_i & b_i;
        for (int gi = 0; gi < NG; gi++) begin
            grp_g[gi] = 1'b0;
            grp_p[gi] = 1'b1;
            for (int k = 0; k < GW; k++) begin
                grp_g[gi] = g[gi*GW+k] | (p[gi*GW+k] & grp_g[gi]);
                grp_p[gi] = grp_p[gi] & p[gi*GW+k];
            end
        end
        grp_c[0] = 1'b0;
        for (int gi = 1; gi < NG; gi++)
            grp_c[gi] = grp_g[gi-1] | (grp_p[gi-1] & grp_c[gi-1]);
        for (int gi = 0; gi < NG; gi++) begin
            cy[gi*GW] = grp_c[gi];
            for (int k = 1; k < GW; k++)
                cy[gi*GW+k] = g[gi*GW+k-1] | (p[gi*GW+k-1] & cy[gi*GW+k-1]);
        end
        sum_o = p ^ cy;
    end

endmodule

// File: rtl/dadda_mul_tree.sv
module dadda_mul_tree #(
    parameter int NROWS   = 9,
    parameter int W       = 48,
    parameter int GW      = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NROWS*W-1:0] rows_i,
    output logic [W-1:0]       prod_o
);
    logic [W-1:0] row_a;
    logic [W-1:0] row_b;
    logic [W-1:0] sum;

    dadda_reduce #(.NROWS(NROWS), .W(W)) u_reduce (
        .rows_i (rows_i),
        .row_a_o(row_a),
        .row_b_o(row_b)
    );

    dadda_cla #(.W(W), .GW(GW)) u_cla (
        .a_i  (row_a),
        .b_i  (row_b),
        .sum_o(sum)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prod_o <= '0;
            else        prod_o <= sum;
        end
    end else begin : g_comb
        assign prod_o = sum;
    end

endmodule

// File: rtl/dadda_mul_tree_chk.sv
module dadda_mul_tree_chk #(
    parameter int NROWS   = 9,
    parameter int W       = 48,
    parameter bit REG_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NROWS*W-1:0] rows_i,
    input logic [W-1:0]       prod_o
);
    logic [W-1:0] ref_sum;
    logic         rows_zero;

    always_comb begin
        ref_sum = '0;
        for (int r = 0; r < NROWS; r++) ref_sum = ref_sum + rows_i[r*W +: W];
        rows_zero = (rows_i == '0);
    end

    if (REG_OUT) begin : g_reg_chk
        AST_REG_SUM: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> prod_o == $past(ref_sum)); // R2
        AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> prod_o == '0); // R3
        AST_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
            rows_zero |=> prod_o == '0); // R7
        AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $stable(rows_i)) |=> $stable(prod_o)); // R8
    end else begin : g_comb_chk
        AST_COMB_SUM: assert property (@(posedge clk) disable iff (!rst_n)
            prod_o == ref_sum); // R1
        AST_COMB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            rows_zero |-> prod_o == '0); // R7
    end

endmodule

bind dadda_mul_tree dadda_mul_tree_chk #(
    .NROWS  (NROWS),
    .W      (W),
    .REG_OUT(REG_OUT)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rows_i(rows_i),
    .prod_o(prod_o)
);

// File: tb/dadda_mul_tree_tb_top.sv
module dadda_mul_tree_tb_top;
    localparam int NR  = 9;
    localparam int WW  = 48;
    localparam int SIG = 24;

    logic              clk   = 1'b0;
    logic              rst_n = 1'b0;
    logic [NR*WW-1:0]  rows  = '0;
    logic [WW-1:0]     prod_r;
    logic [WW-1:0]     prod_c;
    int                n_chk = 0;
    int                n_bad = 0;
    bit                done  = 1'b0;

    always #4 clk = ~clk;

    dadda_mul_tree #(.NROWS(NR), .W(WW), .GW(4), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .rows_i(rows), .prod_o(prod_r)
    );

    dadda_mul_tree #(.NROWS(NR), .W(WW), .GW(4), .REG_OUT(1'b0)) comb_i (
        .clk(clk), .rst_n(rst_n), .rows_i(rows), .prod_o(prod_c)
    );

    function automatic logic [WW-1:0] row_sum(input logic [NR*WW-1:0] v);
        logic [WW-1:0] acc;
        acc = '0;
        for (int r = 0; r < NR; r++) acc = acc + v[r*WW +: WW];
        return acc;
    endfunction

    function automatic logic [NR*WW-1:0] booth_rows(input logic [SIG-1:0] a,
                                                    input logic [SIG-1:0] b);
        logic [SIG+3:0]   y;
        logic [3:0]       grp;
        logic [NR*WW-1:0] v;
        longint           m;
        int               digit;
        y = {3'b000, b, 1'b0};
        v = '0;
        for (int i = 0; i < NR; i++) begin
            grp   = y[3*i +: 4];
            digit = -4 * int'(grp[3]) + 2 * int'(grp[2]) + int'(grp[1]) + int'(grp[0]);
            m     = longint'(digit) * longint'({40'd0, a});
            m     = m <<< (3 * i);
            v[i*WW +: WW] = m[WW-1:0];
        end
        return v;
    endfunction

    function automatic logic [WW-1:0] rnd48();
        logic [63:0] t;
        t = {$urandom, $urandom};
        return t[WW-1:0];
    endfunction

    task automatic check(input string tag, input logic [WW-1:0] got,
                         input logic [WW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // drive at negedge; combinational copy checked 1 ns later, registered
    // copy checked at the following negedge (one rising edge in between)
    task automatic apply(input string tag, input logic [NR*WW-1:0] v,
                         input logic [WW-1:0] exp);
        @(negedge clk);
        rows = v;
        #1;
        check({tag, " R2 comb"}, prod_c, exp);
        @(negedge clk);
        check({tag, " R2 reg"}, prod_r, exp);
    endtask

    task automatic t_reset_state();
        rows = {NR{48'h1234_5678_9ABC}};
        repeat (3) @(negedge clk);
        check("R3 held in reset", prod_r, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 after release", prod_r, row_sum(rows));
    endtask

    task automatic t_zero();
        apply("R7 zero rows", '0, '0);
    endtask

    task automatic t_single_row();
        logic [NR*WW-1:0] v;
        logic [WW-1:0]    x;
        for (int r = 0; r < NR; r++) begin
            x = rnd48() | 48'h8000_0000_0001;
            v = '0;
            v[r*WW +: WW] = x;
            apply($sformatf("R9 lone row %0d", r), v, x);
        end
    endtask

    task automatic t_wrap();
        apply("R5 all ones", {NR*WW{1'b1}}, 48'hFFFF_FFFF_FFF7);
    endtask

    task automatic t_carry_chain();
        logic [NR*WW-1:0] v;
        v = '0;
        v[0 +: WW] = {WW{1'b1}};
        v[WW +: WW] = 48'd1;
        apply("R6 full chain", v, 48'd0);
        v = '0;
        v[0 +: WW] = 48'h0000_0000_0FFF;
        v[5*WW +: WW] = 48'd1;
        apply("R6 group edge", v, 48'h0000_0000_1000);
        v = '0;
        v[2*WW +: WW] = 48'h7FFF_FFFF_FFFF;
        v[8*WW +: WW] = 48'd1;
        apply("R6 top chain", v, 48'h8000_0000_0000);
    endtask

    task automatic t_booth();
        logic [SIG-1:0] a;
        logic [SIG-1:0] b;
        logic [47:0]    p;
        apply("R4 1.0*1.0", booth_rows(24'h800000, 24'h800000), 48'h4000_0000_0000);
        apply("R4 max*max", booth_rows(24'hFFFFFF, 24'hFFFFFF), 48'hFFFF_FE00_0001);
        apply("R4 1.0*max", booth_rows(24'h800000, 24'hFFFFFF), 48'h7FFF_FF80_0000);
        apply("R4 alt bits", booth_rows(24'hAAAAAA, 24'h555555),
              48'(longint'(24'hAAAAAA) * longint'(24'h555555)));
        for (int i = 0; i < 40; i++) begin
            a = 24'($urandom) | 24'h800000;
            b = 24'($urandom) | 24'h800000;
            p = 48'(longint'({40'd0, a}) * longint'({40'd0, b}));
            apply($sformatf("R4 random %0d", i), booth_rows(a, b), p);
        end
    endtask

    task automatic t_random_rows();
        logic [NR*WW-1:0] v;
        for (int i = 0; i < 40; i++) begin
            for (int r = 0; r < NR; r++) v[r*WW +: WW] = rnd48();
            apply($sformatf("R1 random rows %0d", i), v, row_sum(v));
        end
    endtask

    task automatic t_latency_hold();
        logic [NR*WW-1:0] v;
        logic [NR*WW-1:0] w;
        for (int r = 0; r < NR; r++) v[r*WW +: WW] = rnd48();
        for (int r = 0; r < NR; r++) w[r*WW +: WW] = rnd48();
        apply("R2 first", v, row_sum(v));
        @(negedge clk);
        rows = w;
        #1;
        check("R2 not before edge", prod_r, row_sum(v));
        @(negedge clk);
        check("R2 one edge later", prod_r, row_sum(w));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 held", prod_r, row_sum(w));
        end
    endtask

    task automatic t_reset_mid();
        logic [NR*WW-1:0] v;
        for (int r = 0; r < NR; r++) v[r*WW +: WW] = rnd48() | 48'd1;
        apply("R1 before reset", v, row_sum(v));
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R3 async clear", prod_r, '0);
        @(negedge clk);
        check("R3 stays clear", prod_r, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 resume", prod_r, row_sum(v));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_zero();
        t_single_row();
        t_wrap();
        t_carry_chain();
        t_booth();
        t_random_rows();
        t_latency_hold();
        t_reset_mid();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule